// File: doc/BRIEF.md
# USB Device Endpoint Buffer Manager

This block does the buffer bookkeeping for a USB 2.0 device controller with eight endpoints. Endpoint 0 carries control traffic, and endpoints 1 to 7 are user endpoints. A protocol engine presents packets to the block a byte at a time. The block works out where each byte belongs in an external buffer RAM and produces the RAM write strobes. It also answers each packet start with an accept or NAK decision, and for an IN request it supplies the buffer start address and the length.

Firmware reaches the block through a small register port. Through it, firmware configures the endpoints, arms buffers for transmission, releases buffers it has read, and takes interrupts. Each control transfer starts with an 8-byte setup packet, which always lands in a fixed setup slot. Control data uses one buffer that serves both directions. Each user endpoint has a fixed direction and two equal buffers used in ping-pong fashion. A per-endpoint toggle picks the buffer in use. All packet events are reported through one interrupt status register, which has an enable mask.

The RAM is divided into regions of BUF_BYTES bytes each, and BUF_BYTES must be a power of two. Region 0 is the setup slot. Region 1 is the endpoint 0 buffer. User endpoint e, buffer b, is region 2e+b. A byte address is the region number times BUF_BYTES plus the byte offset.

Top module: `usb_ep_buf_mgr`

## Requirements
- R1: A packet started with rxSetup high is always accepted (rxNak low). Its bytes are written to RAM addresses 0 to 7, in order.
- R2: A setup packet ended with rxGood high sets interrupt status bit 0. The bit is readable one cycle after the rxEnd cycle.
- R3: An endpoint 0 data packet is always accepted and written from address BUF_BYTES upward. A good end sets status bit 1 and stores the byte count, which reads back in register 2 bits 6:0.
- R4: A write to register 2 loads the endpoint 0 transmit length and arms the buffer; register 2 bit 7 reads back the armed state. A txReq to endpoint 0 gets txNak while the buffer is unarmed; otherwise it returns txBase = BUF_BYTES and txLen = the loaded length. A good txDone disarms the buffer and sets status bit 2.
- R5: Register 8+e controls user endpoint e. Bit 0 is enable, bit 1 is direction (1 = IN), and bits 3:2 are the type (0 bulk, 1 interrupt, 2 isochronous). All of these read back. Bits 4 and 5 read the full flags of buffers 0 and 1, and bit 6 reads the toggle.
- R6: On an enabled OUT endpoint, a good packet is written at base (2e+tog)*BUF_BYTES. It marks that buffer full, stores its length, flips the toggle and sets status bit 7+e. Register 16+e holds the buffer 0 length in bits 6:0 and the buffer 1 length in bits 14:8.
- R7: A packet to a user endpoint is NAKed (rxNak high in the rxStart cycle) in three cases: the buffer selected by the toggle is still full, the endpoint is disabled, or the endpoint is set to IN. A NAKed packet writes no RAM and changes no status.
- R8: In a write to register 8+e, bit 4 acts on buffer 0 and bit 5 on buffer 1. On an OUT endpoint the set bit releases (empties) that buffer. On an IN endpoint it arms that buffer, with the length taken from bits 14:8.
- R9: On an IN endpoint, txReq gets txNak while the buffer selected by the toggle is unarmed. Otherwise it returns that buffer's base and length. A good txDone empties the buffer, flips the toggle and sets status bit 7+e.
- R10: In a received packet, bytes past the limit are not written. The limit is 8 bytes for a setup packet and BUF_BYTES for any other packet. A good end of such a packet sets only status bit 3: no ready or endpoint bit is set and no length is stored.
- R11: A packet that ends with rxGood low, or a txDone with txGood low, changes no status, flag, length or toggle.
- R12: Register 0 is the interrupt status; writing a 1 to a bit clears it. Register 1 is the enable mask. irq is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStart | input | 1 | First cycle of a received packet |
| rxSetup | input | 1 | The packet starting is a setup packet |
| rxEp | input | 3 | Endpoint number of the packet starting |
| rxValid | input | 1 | rxData holds a payload byte |
| rxData | input | 8 | Payload byte |
| rxEnd | input | 1 | End of the received packet |
| rxGood | input | 1 | The packet ended without error |
| rxNak | output | 1 | The packet in the rxStart cycle is refused |
| txReq | input | 1 | The host asks for an IN packet on txEp |
| txDone | input | 1 | The IN packet on txEp has completed |
| txGood | input | 1 | The host acknowledged the IN packet |
| txEp | input | 3 | Endpoint number for txReq and txDone |
| txNak | output | 1 | The IN request has nothing to send |
| txBase | output | 10 | RAM start address of the buffer to send |
| txLen | output | 7 | Byte count of the buffer to send |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | 10 | RAM write address |
| ramData | output | 8 | RAM write data |
| regAddr | input | 5 | Register address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| irq | output | 1 | Interrupt request |

## Verification
The accept/NAK answer, txBase and txLen are combinational. They are due in the same cycle as rxStart or txReq, so the bench samples them partway through that cycle. A RAM write appears in the cycle its byte is presented, and the bench's memory model captures it at the next edge. Status bits, lengths, flags and toggles change at the edge that closes the rxEnd, txDone or register-write cycle. The bench therefore reads registers only after that edge, once the combinational read data has settled, and drives every input just after an edge.

// File: rtl/usb_epbuf_pkg.sv
package usb_epbuf_pkg;

  // Strobes from control to datapath, issued in the packet start cycle.
  typedef struct packed {
    logic       load;     // a packet begins this cycle
    logic       accept;   // packet goes to RAM
    logic       isSetup;  // use the short setup limit
    logic [7:0] region;   // RAM region index
  } rxCmd_t;

endpackage

// File: rtl/epbuf_datapath.sv
module epbuf_datapath
  import usb_epbuf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 10,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxCmd_t           cmd,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxEnd,
  output logic             ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]       ramData,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             active,
  output logic             isSetup
);

  localparam int SETUP_BYTES = 8;

  logic             activeQ, setupQ, ovfQ;
  logic [7:0]       regionQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limit;
  logic             room;

  assign limit = setupQ ? CNT_W'(SETUP_BYTES) : CNT_W'(BUF_BYTES);
  assign room  = cntQ < limit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      setupQ  <= 1'b0;
      ovfQ    <= 1'b0;
      regionQ <= '0;
      cntQ    <= '0;
    end else if (cmd.load) begin
      activeQ <= cmd.accept;
      setupQ  <= cmd.isSetup;
      regionQ <= cmd.region;
      cntQ    <= '0;
      ovfQ    <= 1'b0;
    end else begin
      if (rxValid && activeQ) begin
        if (room) cntQ <= cntQ + 1'b1;
        else      ovfQ <= 1'b1;
      end
      if (rxEnd) activeQ <= 1'b0;
    end
  end

  assign ramWe   = rxValid && activeQ && room;
  assign ramAddr = ADDR_W'({regionQ, cntQ[OFF_W-1:0]});
  assign ramData = rxData;
  assign count   = cntQ;
  assign ovf     = ovfQ;
  assign active  = activeQ;
  assign isSetup = setupQ;

endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import usb_epbuf_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int BUF_BYTES = 64,
  localparam int EP_W     = $clog2(NUM_EP),
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = OFF_W + 1,
  localparam int ADDR_W   = EP_W + 1 + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxStart,
  input  logic              rxSetup,
  input  logic [EP_W-1:0]   rxEp,
  input  logic              rxEnd,
  input  logic              rxGood,
  output logic              rxNak,
  output rxCmd_t            cmd,
  input  logic [CNT_W-1:0]  dpCount,
  input  logic              dpOvf,
  input  logic              dpActive,
  input  logic              dpSetup,
  input  logic              txReq,
  input  logic              txDone,
  input  logic              txGood,
  input  logic [EP_W-1:0]   txEp,
  output logic              txNak,
  output logic              txBusy,
  output logic [ADDR_W-1:0] txBase,
  output logic [CNT_W-1:0]  txLen,
  input  logic [4:0]        regAddr,
  input  logic              regWe,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              irq,
  output logic [15:0]       isrOut,
  output logic [NUM_EP-1:0] togOut
);

  localparam int BIT_SETUP = 0;
  localparam int BIT_RDY   = 1;
  localparam int BIT_FREE  = 2;
  localparam int BIT_OVF   = 3;
  localparam int BIT_EP    = 7;

  logic [15:0]       isr, ier, isrSet, isrClr;
  logic              ep0Armed;
  logic [CNT_W-1:0]  ep0Len;
  logic [NUM_EP-1:0] cfgEn, cfgDir, tog, full0, full1;
  logic [1:0]        cfgType [NUM_EP];
  logic [CNT_W-1:0]  len0 [NUM_EP];
  logic [CNT_W-1:0]  len1 [NUM_EP];
  logic [EP_W-1:0]   curEp;

  logic              rxAccept;
  logic [7:0]        rxRegion;
  logic              txSel;
  logic [EP_W-1:0]   regEp;
  logic [1:0]        regBank;
  logic              rxOkEnd, rxDataEnd, txOkDone;

  // ---------------- receive admission ----------------
  always_comb begin
    rxAccept = 1'b0;
    rxRegion = '0;
    if (rxSetup) begin
      rxAccept = 1'b1;
      rxRegion = 8'd0;
    end else if (rxEp == '0) begin
      rxAccept = 1'b1;
      rxRegion = 8'd1;
    end else begin
      rxAccept = cfgEn[rxEp] && !cfgDir[rxEp] &&
                 !(tog[rxEp] ? full1[rxEp] : full0[rxEp]);
      rxRegion = 8'({rxEp, tog[rxEp]});
    end
  end

  assign cmd   = '{load: rxStart, accept: rxAccept, isSetup: rxSetup, region: rxRegion};
  assign rxNak = rxStart && !rxAccept;

  // ---------------- transmit lookup ----------------
  assign txSel = tog[txEp];

  always_comb begin
    if (txEp == '0) begin
      txBusy = !ep0Armed;
      txBase = ADDR_W'(BUF_BYTES);
      txLen  = ep0Len;
    end else begin
      txBusy = !(cfgEn[txEp] && cfgDir[txEp] && (txSel ? full1[txEp] : full0[txEp]));
      txBase = {txEp, txSel, {OFF_W{1'b0}}};
      txLen  = txSel ? len1[txEp] : len0[txEp];
    end
  end

  assign txNak = txReq && txBusy;

  // ---------------- event decode ----------------
  assign rxOkEnd   = rxEnd && rxGood && dpActive;
  assign rxDataEnd = rxOkEnd && !dpOvf && !dpSetup;
  assign txOkDone  = txDone && txGood && !txBusy;

  always_comb begin
    isrSet = '0;
    if (rxOkEnd && dpOvf)              isrSet[BIT_OVF]   = 1'b1;
    if (rxOkEnd && !dpOvf && dpSetup)  isrSet[BIT_SETUP] = 1'b1;
    if (rxDataEnd && curEp == '0)      isrSet[BIT_RDY]   = 1'b1;
    if (rxDataEnd && curEp != '0)      isrSet = isrSet | (16'd1 << (BIT_EP + int'(curEp)));
    if (txOkDone && txEp == '0)        isrSet[BIT_FREE]  = 1'b1;
    if (txOkDone && txEp != '0)        isrSet = isrSet | (16'd1 << (BIT_EP + int'(txEp)));
  end

  assign regEp   = regAddr[EP_W-1:0];
  assign regBank = regAddr[4:3];
  assign isrClr  = (regWe && regAddr == 5'd0) ? regWdata : 16'd0;

  // ---------------- register read ----------------
  always_comb begin
    regRdata = '0;
    if (regAddr == 5'd0)      regRdata = isr;
    else if (regAddr == 5'd1) regRdata = ier;
    else if (regAddr == 5'd2) begin
      regRdata[CNT_W-1:0] = ep0Len;
      regRdata[7]         = ep0Armed;
    end else if (regBank == 2'b01) begin
      regRdata[0]   = cfgEn[regEp];
      regRdata[1]   = cfgDir[regEp];
      regRdata[3:2] = cfgType[regEp];
      regRdata[4]   = full0[regEp];
      regRdata[5]   = full1[regEp];
      regRdata[6]   = tog[regEp];
    end else if (regBank == 2'b10) begin
      regRdata[CNT_W-1:0] = len0[regEp];
      regRdata[8+:CNT_W]  = len1[regEp];
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isr      <= '0;
      ier      <= '0;
      ep0Armed <= 1'b0;
      ep0Len   <= '0;
      cfgEn    <= '0;
      cfgDir   <= '0;
      tog      <= '0;
      full0    <= '0;
      full1    <= '0;
      curEp    <= '0;
      for (int e = 0; e < NUM_EP; e++) begin
        cfgType[e] <= '0;
        len0[e]    <= '0;
        len1[e]    <= '0;
      end
    end else begin
      isr <= (isr & ~isrClr) | isrSet;
      if (rxStart) curEp <= rxSetup ? '0 : rxEp;

      // firmware writes
      if (regWe) begin
        if (regAddr == 5'd1) ier <= regWdata;
        if (regAddr == 5'd2) begin
          ep0Len   <= regWdata[CNT_W-1:0];
          ep0Armed <= 1'b1;
        end
        if (regBank == 2'b01 && regEp != '0) begin
          cfgEn[regEp]   <= regWdata[0];
          cfgDir[regEp]  <= regWdata[1];
          cfgType[regEp] <= regWdata[3:2];
          if (regWdata[4]) begin
            full0[regEp] <= regWdata[1];
            if (regWdata[1]) len0[regEp] <= regWdata[8+:CNT_W];
          end
          if (regWdata[5]) begin
            full1[regEp] <= regWdata[1];
            if (regWdata[1]) len1[regEp] <= regWdata[8+:CNT_W];
          end
        end
      end

      // completed receive
      if (rxDataEnd) begin
        if (curEp == '0) ep0Len <= dpCount;
        else begin
          if (tog[curEp]) begin
            full1[curEp] <= 1'b1;
            len1[curEp]  <= dpCount;
          end else begin
            full0[curEp] <= 1'b1;
            len0[curEp]  <= dpCount;
          end
          tog[curEp] <= ~tog[curEp];
        end
      end

      // completed transmit
      if (txOkDone) begin
        if (txEp == '0) ep0Armed <= 1'b0;
        else begin
          if (txSel) full1[txEp] <= 1'b0;
          else       full0[txEp] <= 1'b0;
          tog[txEp] <= ~tog[txEp];
        end
      end
    end
  end

  assign irq    = |(isr & ier);
  assign isrOut = isr;
  assign togOut = tog;

endmodule

// File: rtl/usb_ep_buf_mgr.sv
module usb_ep_buf_mgr
  import usb_epbuf_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int BUF_BYTES = 64,
  localparam int EP_W     = $clog2(NUM_EP),
  localparam int CNT_W    = $clog2(BUF_BYTES) + 1,
  localparam int ADDR_W   = $clog2(2 * NUM_EP * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxStart,
  input  logic              rxSetup,
  input  logic [EP_W-1:0]   rxEp,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic              rxGood,
  output logic              rxNak,
  input  logic              txReq,
  input  logic              txDone,
  input  logic              txGood,
  input  logic [EP_W-1:0]   txEp,
  output logic              txNak,
  output logic [ADDR_W-1:0] txBase,
  output logic [CNT_W-1:0]  txLen,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  input  logic [4:0]        regAddr,
  input  logic              regWe,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              irq
);

  rxCmd_t            cmd;
  logic [CNT_W-1:0]  dpCount;
  logic              dpOvf, dpActive, dpSetup, txBusy;
  logic [15:0]       isrOut;
  logic [NUM_EP-1:0] togOut;

  epbuf_ctrl #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES)) ctrl (
    .clk(clk), .rstN(rstN),
    .rxStart(rxStart), .rxSetup(rxSetup), .rxEp(rxEp),
    .rxEnd(rxEnd), .rxGood(rxGood), .rxNak(rxNak), .cmd(cmd),
    .dpCount(dpCount), .dpOvf(dpOvf), .dpActive(dpActive), .dpSetup(dpSetup),
    .txReq(txReq), .txDone(txDone), .txGood(txGood), .txEp(txEp),
    .txNak(txNak), .txBusy(txBusy), .txBase(txBase), .txLen(txLen),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .irq(irq), .isrOut(isrOut), .togOut(togOut)
  );

  epbuf_datapath #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .count(dpCount), .ovf(dpOvf), .active(dpActive), .isSetup(dpSetup)
  );

endmodule

// File: rtl/usb_ep_buf_mgr_chk.sv
module usb_ep_buf_mgr_chk #(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxStart,
  input logic              rxNak,
  input logic              rxEnd,
  input logic              rxGood,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              txDone,
  input logic              txGood,
  input logic              txBusy,
  input logic [EP_W-1:0]   txEp,
  input logic              regWe,
  input logic [15:0]       isrOut,
  input logic [NUM_EP-1:0] togOut,
  input logic              dpOvf,
  input logic              dpSetup,
  input logic              dpActive
);

  AST_SETUP_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && dpSetup) |-> (ramAddr < ADDR_W'(8))); // R1

  AST_SETUP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnd && rxGood && dpActive && dpSetup && !dpOvf) |=> isrOut[0]); // R2

  AST_NAK_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rxStart && rxNak) |=> !ramWe); // R7

  AST_TX_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && txGood && !txBusy && txEp != '0) |=> (togOut != $past(togOut))); // R9

  AST_OVF_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnd && rxGood && dpActive && dpOvf && !regWe && !txDone)
      |=> (isrOut == ($past(isrOut) | 16'h0008))); // R10

endmodule

bind usb_ep_buf_mgr usb_ep_buf_mgr_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxNak(rxNak), .rxEnd(rxEnd),
  .rxGood(rxGood), .ramWe(ramWe), .ramAddr(ramAddr), .txDone(txDone),
  .txGood(txGood), .txBusy(txBusy), .txEp(txEp), .regWe(regWe),
  .isrOut(isrOut), .togOut(togOut), .dpOvf(dpOvf), .dpSetup(dpSetup),
  .dpActive(dpActive)
);

// File: tb/usb_ep_buf_mgr_test.sv
module usb_ep_buf_mgr_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxStart = 0, rxSetup = 0, rxValid = 0, rxEnd = 0, rxGood = 0;
  logic [2:0]  rxEp = 0;
  logic [7:0]  rxData = 0;
  logic        rxNak;
  logic        txReq = 0, txDone = 0, txGood = 0;
  logic [2:0]  txEp = 0;
  logic        txNak;
  logic [9:0]  txBase;
  logic [6:0]  txLen;
  logic        ramWe;
  logic [9:0]  ramAddr;
  logic [7:0]  ramData;
  logic [4:0]  regAddr = 0;
  logic        regWe = 0;
  logic [15:0] regWdata = 0;
  logic [15:0] regRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_ep_buf_mgr uut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxSetup(rxSetup), .rxEp(rxEp),
    .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd), .rxGood(rxGood), .rxNak(rxNak),
    .txReq(txReq), .txDone(txDone), .txGood(txGood), .txEp(txEp), .txNak(txNak),
    .txBase(txBase), .txLen(txLen), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  logic [7:0] mem [0:1023];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramData;

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((v * 37 + i) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // All tasks start and end one time unit after a rising edge.
  task automatic writeReg(input int a, input logic [15:0] d);
    regWe = 1; regAddr = 5'(a); regWdata = d;
    @(posedge clk); #1 regWe = 0;
  endtask

  task automatic readReg(input int a, output logic [15:0] v);
    regAddr = 5'(a);
    #1 v = regRdata;
    @(posedge clk); #1;
  endtask

  task automatic sendRx(input int ep, input bit setup, input int n, input bit good,
                        input int v, output bit nak);
    rxStart = 1; rxEp = 3'(ep); rxSetup = setup;
    #1 nak = rxNak;
    @(posedge clk); #1 rxStart = 0; rxSetup = 0;
    for (int i = 0; i < n; i++) begin
      rxValid = 1; rxData = pat(v, i);
      @(posedge clk); #1;
    end
    rxValid = 0; rxEnd = 1; rxGood = good;
    @(posedge clk); #1 rxEnd = 0; rxGood = 0;
  endtask

  task automatic askTx(input int ep, output bit nak, output int base, output int len);
    txReq = 1; txEp = 3'(ep);
    #1 nak = txNak; base = int'(txBase); len = int'(txLen);
    @(posedge clk); #1 txReq = 0;
  endtask

  task automatic finishTx(input int ep, input bit good);
    txDone = 1; txGood = good; txEp = 3'(ep);
    @(posedge clk); #1 txDone = 0; txGood = 0;
  endtask

  // Fields: ep[31:29] setup[28] bytes[27:20] good[19] nak[18] isr[15:0]
  localparam logic [31:0] VEC [0:8] = '{
    {3'd0, 1'b1, 8'd8,  1'b1, 1'b0, 2'b0, 16'h0001},
    {3'd0, 1'b0, 8'd10, 1'b1, 1'b0, 2'b0, 16'h0002},
    {3'd0, 1'b0, 8'd70, 1'b1, 1'b0, 2'b0, 16'h0008},
    {3'd1, 1'b0, 8'd5,  1'b1, 1'b0, 2'b0, 16'h0100},
    {3'd1, 1'b0, 8'd64, 1'b1, 1'b0, 2'b0, 16'h0100},
    {3'd1, 1'b0, 8'd3,  1'b1, 1'b1, 2'b0, 16'h0000},
    {3'd2, 1'b0, 8'd4,  1'b1, 1'b1, 2'b0, 16'h0000},
    {3'd3, 1'b0, 8'd4,  1'b1, 1'b1, 2'b0, 16'h0000},
    {3'd0, 1'b1, 8'd8,  1'b0, 1'b0, 2'b0, 16'h0000}
  };

  function automatic string vecReq(input int i);
    case (i)
      0: return "R1 R2";
      1: return "R3";
      2: return "R10";
      3, 4: return "R6";
      5, 6, 7: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    logic [15:0] v;
    bit nak;
    int base, len;

    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // reset state
    readReg(0, v); check("R12 reset isr", 32'(v), 0);
    check("R12 reset irq", 32'(irq), 0);
    readReg(9, v); check("R5 reset ep1 cfg", 32'(v), 0);

    // ep1 OUT isochronous, ep2 IN bulk
    writeReg(9, 16'h0009);
    writeReg(10, 16'h0003);
    readReg(9, v); check("R5 ep1 cfg readback", 32'(v), 32'h0009);

    for (int k = 0; k < 9; k++) begin
      sendRx(int'(VEC[k][31:29]), VEC[k][28], int'(VEC[k][27:20]), VEC[k][19], k, nak);
      check({vecReq(k), " nak"}, 32'(nak), 32'(VEC[k][18]));
      readReg(0, v);
      check({vecReq(k), " isr"}, 32'(v), 32'(VEC[k][15:0]));
      writeReg(0, 16'hFFFF);
    end

    // data placement
    check("R1 setup slot byte", 32'(mem[3]), 32'(pat(8, 3)));
    check("R1 setup slot end", 32'(mem[7]), 32'(pat(8, 7)));
    check("R10 ep0 last kept byte", 32'(mem[64 + 63]), 32'(pat(2, 63)));
    check("R10 no write past limit", 32'(mem[128]), 32'(pat(3, 0)));
    check("R6 ep1 buf0 byte", 32'(mem[128 + 4]), 32'(pat(3, 4)));
    check("R6 ep1 buf1 byte", 32'(mem[192 + 63]), 32'(pat(4, 63)));
    readReg(2, v); check("R10 ep0 length kept", 32'(v), 32'd10);
    readReg(17, v); check("R6 ep1 lengths", 32'(v), 32'h4005);
    readReg(9, v); check("R7 ep1 status after nak", 32'(v), 32'h0039);
    readReg(10, v); check("R7 ep2 status after nak", 32'(v), 32'h0003);

    // release buffer 0 and receive again
    writeReg(9, 16'h0019);
    readReg(9, v); check("R8 release buf0", 32'(v), 32'h0029);
    sendRx(1, 0, 3, 1, 9, nak);
    check("R6 accept after release", 32'(nak), 0);
    readReg(9, v); check("R6 status after refill", 32'(v), 32'h0079);
    readReg(17, v); check("R6 lengths after refill", 32'(v), 32'h4003);
    check("R6 refill data", 32'(mem[128 + 2]), 32'(pat(9, 2)));
    writeReg(0, 16'hFFFF);

    // IN endpoint 2
    askTx(2, nak, base, len);
    check("R9 unarmed nak", 32'(nak), 1);
    writeReg(10, 16'h0C13);
    readReg(10, v); check("R8 arm buf0", 32'(v), 32'h0013);
    askTx(2, nak, base, len);
    check("R9 armed ack", 32'(nak), 0);
    check("R9 base buf0", 32'(base), 256);
    check("R9 len buf0", 32'(len), 12);
    finishTx(2, 1);
    readReg(0, v); check("R9 isr ep2", 32'(v), 32'h0200);
    readReg(10, v); check("R9 status after send", 32'(v), 32'h0043);
    writeReg(0, 16'hFFFF);
    askTx(2, nak, base, len);
    check("R9 other buffer unarmed", 32'(nak), 1);
    writeReg(10, 16'h0723);
    askTx(2, nak, base, len);
    check("R9 base buf1", 32'(base), 320);
    check("R9 len buf1", 32'(len), 7);
    finishTx(2, 0);
    readReg(0, v); check("R11 bad tx isr", 32'(v), 0);
    readReg(10, v); check("R11 bad tx status", 32'(v), 32'h0063);

    // endpoint 0 transmit
    askTx(0, nak, base, len);
    check("R4 ep0 unarmed nak", 32'(nak), 1);
    writeReg(2, 16'd20);
    readReg(2, v); check("R4 ep0 armed", 32'(v), 32'h0094);
    askTx(0, nak, base, len);
    check("R4 ep0 ack", 32'(nak), 0);
    check("R4 ep0 base", 32'(base), 64);
    check("R4 ep0 len", 32'(len), 20);
    finishTx(0, 1);
    readReg(0, v); check("R4 free bit", 32'(v), 32'h0004);
    readReg(2, v); check("R4 disarmed", 32'(v), 32'h0014);

    // interrupt mask and clear
    check("R12 irq masked", 32'(irq), 0);
    writeReg(1, 16'h0004);
    check("R12 irq enabled", 32'(irq), 1);
    writeReg(1, 16'h0001);
    check("R12 irq other mask", 32'(irq), 0);
    writeReg(0, 16'h0004);
    readReg(0, v); check("R12 write one clears", 32'(v), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule